// File: doc/BRIEF.md
# ADC Parallel-Bus Control Core

This block is the digital side of a multichannel successive-approximation converter as a microprocessor sees it. The processor uses active-low chip select, write and read strobes and a 10-bit data word. A write loads a 10-bit control word. In the normal case, that write also starts an acquisition followed by one conversion, or by two back-to-back conversions. Reads return the stored conversion results. One active-low status output works either as a busy level or as a sticky interrupt. The analog track-and-hold, comparator and reference sit outside the block. The block drives them through a start/abort/done/result handshake toward a SAR sequencer.

The bus strobes are asynchronous to the converter clock. The block passes them through a synchronizer and detects their edges in the clock domain. The data port is split into an input word, an output word and an output enable, and the pad ring builds the tri-state driver from them. Write data must be valid during the final synchronizer cycles of the write strobe's low phase.

Control word fields:
- bits 2:0: first channel
- bits 5:3: second channel
- bit 6: dual conversion
- bit 7: half-scale test, which converts the reference
- bit 8: power-down
- bit 9: interrupt mode for the status output

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset the control word is all zeros, so the block is in single-conversion, busy-flag mode. The status output is high, the data port is not driven, and reads return 0.
- R2: The data port output enable is high only while chip select and read are both low.
- R3: A control write with bit 8 at 0 starts an acquisition of ACQ_CYC clocks. A conversion request to the SAR follows on the channel in bits 2:0. Its result is stored in result register 1.
- R4: With bit 6 at 1, a second conversion starts as soon as the first finishes, on the channel in bits 5:3. Its result is stored in result register 2.
- R5: With bit 9 at 0, the status output is low from the start of acquisition until the last conversion ends. It does not rise between the two conversions of a dual run.
- R6: With bit 9 at 1, the status output goes low when the last conversion ends. It stays low until a falling write or read strobe while chip select is low.
- R7: With bit 6 at 0, every read returns result register 1. With bit 6 at 1, reads alternate between register 1 and register 2, beginning with register 1. Every control write resets the alternation to register 1.
- R8: A read that begins during acquisition or conversion aborts the SAR. Nothing is stored, and in busy-flag mode the status output returns high.
- R9: A write that begins during acquisition or conversion aborts it at the falling strobe. In busy-flag mode the status output is then high. The rising strobe starts a fresh sequence with the new control word.
- R10: A write with bit 8 at 1 starts no conversion and aborts any running one. The previously stored results stay readable.
- R11: A later write with bit 8 at 0 starts a conversion sequence without any further command. Its results overwrite the stored ones.
- R12: With bit 7 at 1, the SAR is told to convert the reference, whatever the channel fields hold. Bit 6 still selects one or two conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| db_in | input | 10 | Data word from the bus |
| db_out | output | 10 | Selected result word toward the bus |
| db_oe | output | 1 | Output enable for the data pads |
| flag_n | output | 1 | Busy level or sticky interrupt, active low |
| sar_start | output | 1 | One-cycle request to begin a conversion |
| sar_abort | output | 1 | One-cycle request to stop the running conversion |
| sar_chan | output | 3 | Channel for the requested conversion |
| sar_ref | output | 1 | Convert the reference instead of a channel |
| sar_done | input | 1 | One-cycle pulse at the end of a conversion |
| sar_result | input | 10 | Conversion result, valid with sar_done |

## Verification
The hardest condition to reach from the ports is a bus access that arrives inside the short window in which the sequencer is busy. An abort pulse must appear, no result may be stored, and, for a write, a fresh sequence must restart. The bench pairs the block with a behavioural SAR of fixed 14-clock latency and counts its start and abort pulses. It issues a read, a normal write or a power-down write a fixed number of clocks after a starting write, which lands the access in the middle of the first conversion. It then checks the start and abort counts and reads back the stored words.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  localparam int DATA_W  = 10;
  localparam int CH_W    = 3;
  localparam int NUM_RES = 2;

  // Field order matches the bit positions decoded from the bus word.
  typedef struct packed {
    logic            int_mode;
    logic            pwr_down;
    logic            half_scale;
    logic            dual;
    logic [CH_W-1:0] ch_b;
    logic [CH_W-1:0] ch_a;
  } ctl_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ACQ   = 2'd1,
    SQ_CONV1 = 2'd2,
    SQ_CONV2 = 2'd3
  } seq_st_t;
endpackage

// File: rtl/adc_bus_sync.sv
module adc_bus_sync
  import adc_bus_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int W      = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic [W-1:0] db_in,
  output logic         wr_fall,
  output logic         wr_rise,
  output logic         rd_fall,
  output logic         rd_rise,
  output logic [W-1:0] wr_word
);
  // Each stage holds {cs, wr, rd}.
  logic [STAGES-1:0][2:0] stg_q;
  logic [2:0]             lvl_q;
  logic [2:0]             cur;
  logic [W-1:0]           word_q;
  logic [W-1:0]           word_d;
  logic                   word_en;

  assign cur     = stg_q[STAGES-1];
  assign word_en = ~cur[1];

  always_comb begin
    word_d = word_q;
    if (word_en) word_d = db_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      lvl_q  <= '1;
      word_q <= '0;
    end else begin
      stg_q[0] <= {cs_n, wr_n, rd_n};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      lvl_q  <= cur;
      word_q <= word_d;
    end
  end

  // Edges only count while chip select is low in the synchronized domain.
  assign wr_fall = lvl_q[1] & ~cur[1] & ~cur[2];
  assign wr_rise = ~lvl_q[1] & cur[1] & ~lvl_q[2];
  assign rd_fall = lvl_q[0] & ~cur[0] & ~cur[2];
  assign rd_rise = ~lvl_q[0] & cur[0] & ~lvl_q[2];
  assign wr_word = word_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_bus_pkg::*;
#(
  parameter int ACQ_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            bus_hit,
  input  logic            dual,
  input  logic [CH_W-1:0] ch_a,
  input  logic [CH_W-1:0] ch_b,
  input  logic            sar_done,
  output logic            sar_start,
  output logic            sar_abort,
  output logic [CH_W-1:0] sar_chan,
  output logic            busy,
  output logic            store_1,
  output logic            store_2,
  output logic            finish
);
  localparam int CW = (ACQ_CYC > 1) ? $clog2(ACQ_CYC) : 1;

  seq_st_t         st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            use_b;

  assign busy = (st_q != SQ_IDLE);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sar_start = 1'b0;
    store_1   = 1'b0;
    store_2   = 1'b0;
    finish    = 1'b0;
    use_b     = (st_q == SQ_CONV2);
    sar_abort = busy & (bus_hit | start_req);
    if (start_req) begin
      st_d  = SQ_ACQ;
      cnt_d = CW'(ACQ_CYC - 1);
    end else if (sar_abort) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_ACQ: begin
          if (cnt_q == '0) begin
            sar_start = 1'b1;
            st_d      = SQ_CONV1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        SQ_CONV1: begin
          if (sar_done) begin
            store_1 = 1'b1;
            if (dual) begin
              sar_start = 1'b1;
              use_b     = 1'b1;
              st_d      = SQ_CONV2;
            end else begin
              finish = 1'b1;
              st_d   = SQ_IDLE;
            end
          end
        end
        SQ_CONV2: begin
          if (sar_done) begin
            store_2 = 1'b1;
            finish  = 1'b1;
            st_d    = SQ_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sar_chan = use_b ? ch_b : ch_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bus_pkg::*;
#(
  parameter int NREG = NUM_RES,
  parameter int W    = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] store,
  input  logic [W-1:0]    sar_result,
  input  logic            sel_clr,
  input  logic            sel_adv,
  input  logic            multi,
  output logic [W-1:0]    rd_word
);
  localparam int SW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][W-1:0] res_all;
  logic [SW-1:0]          sel_q, sel_d;

  for (genvar g = 0; g < NREG; g++) begin : g_res
    logic [W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r_q <= '0;
      else if (store[g]) r_q <= sar_result;
    end
    assign res_all[g] = r_q;
  end

  always_comb begin
    sel_d = sel_q;
    if (sel_clr) begin
      sel_d = '0;
    end else if (sel_adv && multi) begin
      if (sel_q == SW'(NREG - 1)) sel_d = '0;
      else                        sel_d = sel_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign rd_word = res_all[sel_q];
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int ACQ_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic              flag_n,
  output logic              sar_start,
  output logic              sar_abort,
  output logic [CH_W-1:0]   sar_chan,
  output logic              sar_ref,
  input  logic              sar_done,
  input  logic [DATA_W-1:0] sar_result
);
  logic [1:0]        rst_pipe;
  logic              rst_i_n;
  logic              wr_fall, wr_rise, rd_fall, rd_rise;
  logic [DATA_W-1:0] wr_word;
  ctl_t              wr_ctl;
  ctl_t              cfg_q, cfg_d;
  logic              int_pend_q, int_pend_d;
  logic              start_req, bus_hit;
  logic              busy, store_1, store_2, finish;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  adc_bus_sync #(.STAGES(SYNC_STAGES), .W(DATA_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .db_in   (db_in),
    .wr_fall (wr_fall),
    .wr_rise (wr_rise),
    .rd_fall (rd_fall),
    .rd_rise (rd_rise),
    .wr_word (wr_word)
  );

  assign wr_ctl    = ctl_t'(wr_word);
  assign start_req = wr_rise & ~wr_ctl.pwr_down;
  assign bus_hit   = wr_fall | rd_fall;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_rise) cfg_d = wr_ctl;
  end

  always_comb begin
    int_pend_d = int_pend_q;
    if (bus_hit)                     int_pend_d = 1'b0;
    else if (finish && cfg_q.int_mode) int_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q      <= '0;
      int_pend_q <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      int_pend_q <= int_pend_d;
    end
  end

  adc_conv_seq #(.ACQ_CYC(ACQ_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start_req (start_req),
    .bus_hit   (bus_hit),
    .dual      (cfg_q.dual),
    .ch_a      (cfg_q.ch_a),
    .ch_b      (cfg_q.ch_b),
    .sar_done  (sar_done),
    .sar_start (sar_start),
    .sar_abort (sar_abort),
    .sar_chan  (sar_chan),
    .busy      (busy),
    .store_1   (store_1),
    .store_2   (store_2),
    .finish    (finish)
  );

  adc_result_bank #(.NREG(NUM_RES), .W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .store      ({store_2, store_1}),
    .sar_result (sar_result),
    .sel_clr    (wr_rise),
    .sel_adv    (rd_rise),
    .multi      (cfg_q.dual),
    .rd_word    (db_out)
  );

  assign sar_ref = cfg_q.half_scale;
  assign db_oe   = ~cs_n & ~rd_n;
  assign flag_n  = cfg_q.int_mode ? ~int_pend_q : ~busy;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic flag_n,
  input logic sar_start,
  input logic sar_abort,
  input logic busy,
  input logic int_mode,
  input logic pwr_down,
  input logic wr_fall,
  input logic rd_fall,
  input logic wr_rise
);
  // R3: a conversion request only comes out of an active sequence
  p_start_in_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sar_start |-> busy);

  // R9: start and abort never coincide
  p_start_abort_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sar_start && sar_abort));

  // R6: interrupt stays low until a bus strobe clears it
  p_int_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && !flag_n && !wr_fall && !rd_fall) |=> !flag_n);

  // R6: the interrupt falls only once the sequence has ended
  p_int_fall_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && $fell(flag_n)) |-> !busy);

  // R8: after an abort in busy mode the flag is released
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_abort && !int_mode && !wr_rise) |=> flag_n);

  // R10: no conversion is requested while powered down
  p_pd_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !sar_start);
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .flag_n    (flag_n),
  .sar_start (sar_start),
  .sar_abort (sar_abort),
  .busy      (busy),
  .int_mode  (cfg_q.int_mode),
  .pwr_down  (cfg_q.pwr_down),
  .wr_fall   (wr_fall),
  .rd_fall   (rd_fall),
  .wr_rise   (wr_rise)
);

// File: tb/sim_adc_bus_ctrl.sv
`timescale 1ns/1ps
module sim_adc_bus_ctrl;
  localparam int CONV = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, rd_n;
  logic [9:0] db_in;
  logic [9:0] db_out;
  logic       db_oe, flag_n;
  logic       sar_start, sar_abort, sar_ref;
  logic [2:0] sar_chan;
  logic       m_done;
  logic [9:0] m_res;

  int vec  = 0;
  int fail = 0;
  int cyc  = 0;

  always #2.5 clk = ~clk;

  adc_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .flag_n(flag_n),
    .sar_start(sar_start), .sar_abort(sar_abort), .sar_chan(sar_chan),
    .sar_ref(sar_ref), .sar_done(m_done), .sar_result(m_res)
  );

  // Behavioural SAR: fixed latency, result tags the start count and channel.
  int         starts = 0, aborts = 0, rises = 0, m_cnt = 0;
  logic       m_act = 1'b0, flag_prev = 1'b1;
  logic [2:0] m_ch = '0;
  logic       m_ref = 1'b0;

  always @(posedge clk) begin
    m_done    <= 1'b0;
    flag_prev <= flag_n;
    if (flag_n === 1'b1 && flag_prev === 1'b0) rises <= rises + 1;
    if (!rst_n) begin
      m_act <= 1'b0;
      m_res <= '0;
    end else if (sar_abort) begin
      m_act  <= 1'b0;
      aborts <= aborts + 1;
    end else if (sar_start) begin
      m_act  <= 1'b1;
      m_cnt  <= CONV;
      m_ch   <= sar_chan;
      m_ref  <= sar_ref;
      starts <= starts + 1;
    end else if (m_act) begin
      if (m_cnt == 1) begin
        m_act  <= 1'b0;
        m_done <= 1'b1;
        m_res  <= m_ref ? 10'd0 : {starts[6:0], m_ch};
      end
      m_cnt <= m_cnt - 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec + 1, fail + 1);
      $finish;
    end
  end

  function automatic logic [9:0] ex(int n, logic [2:0] ch, logic hs);
    logic [6:0] n7;
    n7 = n[6:0];
    return hs ? 10'd0 : {n7, ch};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [9:0] v);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; db_in = v;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_read(output logic [9:0] v);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    v = db_out;
    chk("R2", "oe during read", int'(db_oe), 1);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic wait_done(int target);
    while (!(starts == target && !m_act)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  logic [9:0] last1, last2;

  task automatic run(logic im, logic dual, logic hs, logic [2:0] a, logic [2:0] b);
    logic [9:0] r, e1, e2;
    int s0, r0;
    s0 = starts; r0 = rises;
    bus_write({im, 1'b0, hs, dual, b, a});
    if (!im) chk("R5", "flag low during run", int'(flag_n), 0);
    wait_done(s0 + (dual ? 2 : 1));
    e1 = ex(s0 + 1, a, hs);
    e2 = ex(s0 + 2, b, hs);
    if (!im) begin
      chk("R5", "flag high at end", int'(flag_n), 1);
      chk("R5", "single flag rise", rises - r0, 1);
    end else begin
      chk("R6", "int low at end", int'(flag_n), 0);
      repeat (20) @(negedge clk);
      chk("R6", "int sticky", int'(flag_n), 0);
    end
    bus_read(r);
    chk(hs ? "R12" : "R3", "first read", int'(r), int'(e1));
    if (im) chk("R6", "int cleared by read", int'(flag_n), 1);
    if (dual) begin
      bus_read(r);
      chk(hs ? "R12" : "R4", "second read", int'(r), int'(e2));
      bus_read(r);
      chk("R7", "third read wraps", int'(r), int'(e1));
      last2 = e2;
    end else begin
      bus_read(r);
      chk("R7", "single repeat", int'(r), int'(e1));
    end
    last1 = e1;
  endtask

  initial begin
    logic [9:0] r;
    int s0, a0;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; db_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1", "flag after reset", int'(flag_n), 1);
    chk("R1", "oe after reset", int'(db_oe), 0);
    bus_read(r);
    chk("R1", "read after reset", int'(r), 0);
    bus_read(r);
    chk("R1", "second read after reset", int'(r), 0);

    // R2: enable needs both strobes low
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "oe with cs only", int'(db_oe), 0);
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "oe with rd only", int'(db_oe), 0);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep: flag mode, conversion count, every first channel
    for (int im = 0; im < 2; im++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 8; a++)
          run(im[0], d[0], 1'b0, a[2:0], 3'(7 - a));

    // R12: half-scale ignores channel fields
    run(1'b0, 1'b0, 1'b1, 3'd5, 3'd6);
    run(1'b0, 1'b1, 1'b1, 3'd3, 3'd4);
    run(1'b0, 1'b0, 1'b0, 3'd2, 3'd0);

    // R8: read inside a conversion
    s0 = starts;
    bus_write(10'h005);
    repeat (6) @(negedge clk);
    a0 = aborts;
    bus_read(r);
    chk("R8", "abort on read", aborts - a0, 1);
    repeat (30) @(negedge clk);
    chk("R8", "flag released", int'(flag_n), 1);
    chk("R8", "no restart", starts - s0, 1);
    bus_read(r);
    chk("R8", "result kept", int'(r), int'(last1));

    // R9: write inside a conversion
    bus_write(10'h001);
    repeat (6) @(negedge clk);
    a0 = aborts; s0 = starts;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; db_in = 10'h004;
    repeat (4) @(negedge clk);
    chk("R9", "abort on write", aborts - a0, 1);
    chk("R9", "flag high after falling strobe", int'(flag_n), 1);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    wait_done(s0 + 1);
    bus_read(r);
    chk("R9", "new sequence result", int'(r), int'(ex(s0 + 1, 3'd4, 1'b0)));
    last1 = r;

    // R10: power-down while idle keeps results
    s0 = starts;
    bus_write(10'h100);
    repeat (50) @(negedge clk);
    chk("R10", "no start in power-down", starts - s0, 0);
    chk("R10", "flag idle in power-down", int'(flag_n), 1);
    bus_read(r);
    chk("R10", "result kept", int'(r), int'(last1));

    // R10: power-down during a conversion aborts it
    bus_write(10'h003);
    repeat (6) @(negedge clk);
    a0 = aborts; s0 = starts;
    bus_write(10'h100);
    chk("R10", "abort on power-down", aborts - a0, 1);
    repeat (40) @(negedge clk);
    chk("R10", "no restart", starts - s0, 0);
    chk("R10", "flag released", int'(flag_n), 1);
    bus_read(r);
    chk("R10", "older result kept", int'(r), int'(last1));

    // R11: leaving power-down converts and overwrites
    s0 = starts;
    bus_write({4'b0001, 3'd1, 3'd6});
    wait_done(s0 + 2);
    bus_read(r);
    chk("R11", "overwrite reg 1", int'(r), int'(ex(s0 + 1, 3'd6, 1'b0)));
    bus_read(r);
    chk("R11", "overwrite reg 2", int'(r), int'(ex(s0 + 2, 3'd1, 1'b0)));

    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end
endmodule